// File: doc/BRIEF.md
# Camera follow and parallax scroll unit

This block keeps a two-axis camera for a tile-based display. Once per frame, on a single-cycle tick, it moves a signed 16-bit camera position halfway toward a target point on each axis and then limits the result to a programmable window. From the settled camera it derives packed 16-bit scroll words for two layers. The foreground layer moves one pixel per camera pixel. The background layer moves at half that rate, which gives a parallax effect.

The vertical scroll byte can be produced in one of two ways. In the first, it is the negated camera Y plus a per-level correction byte, for a display whose vertical axis runs against the camera's. In the second, it is the camera Y itself.

A small sequencer runs each frame update through four named states:

- `ST_IDLE` waits for a tick. It takes transition *accept* to `ST_FOLLOW` on a tick and stays in place otherwise.
- `ST_FOLLOW` computes the half step. It takes transition *step* to `ST_CLAMP` unconditionally.
- `ST_CLAMP` applies the window limits. It takes transition *settle* to `ST_EMIT` unconditionally.
- `ST_EMIT` loads both scroll words. It takes transition *finish* back to `ST_IDLE` unconditionally.

Target, bounds, correction and mode are all captured on the accepting edge. Changes to those inputs later in the update have no effect on it.

Top module: `cam_scroll_unit`

## Requirements
- R1: A `frame_tick` seen high on a clock edge while idle captures all target, bound, correction and mode inputs. The camera outputs take their new value on the second edge after that one. The scroll words take theirs on the third edge after it.
- R2: The follow step on each axis sets the camera to camera + floor((target − camera) / 2). The difference is formed in 17 bits, so a camera of −32768 with a target of 32767 gives −1.
- R3: After the step, a value above the maximum becomes the maximum. A value below the minimum then becomes the minimum, so the minimum wins when the minimum is greater than the maximum.
- R4: Foreground scroll word bits [7:0] hold camera X modulo 256. Bits [15:8] hold the foreground Y byte.
- R5: Background scroll word bits [7:0] hold floor(camera X / 2) modulo 256. Bits [15:8] hold the Y byte computed from floor(camera Y / 2).
- R6: With `y_invert` = 1, the Y byte of a layer is (correction − layer Y) modulo 256. With `y_invert` = 0, it is layer Y modulo 256. Layer Y is camera Y for the foreground and floor(camera Y / 2) for the background.
- R7: A tick arriving during the three cycles after an accepting edge is ignored. The next tick is accepted on the fourth edge after the accepting edge at the earliest.
- R8: The camera outputs hold their value except on the settle edge. The scroll words hold their value except on the finish edge.
- R9: After reset, both camera coordinates and both scroll words are zero and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle request for a frame update |
| tgt_x | input | 16 | Signed target X in pixels |
| tgt_y | input | 16 | Signed target Y in pixels |
| min_x | input | 16 | Signed lower camera X limit |
| max_x | input | 16 | Signed upper camera X limit |
| min_y | input | 16 | Signed lower camera Y limit |
| max_y | input | 16 | Signed upper camera Y limit |
| y_corr | input | 8 | Correction byte added in inverted-Y mode |
| y_invert | input | 1 | 1 selects inverted Y bytes, 0 selects direct Y bytes |
| cam_x | output | 16 | Signed camera X |
| cam_y | output | 16 | Signed camera Y |
| scr_main | output | 16 | Foreground scroll word, Y byte high, X byte low |
| scr_para | output | 16 | Background half-rate scroll word, Y byte high, X byte low |

## Verification
The camera outputs change on the second rising edge after the accepting edge, and the scroll words change one edge later. A tick accepted on edge k therefore yields new camera values after edge k+2 and new scroll words after edge k+3, with no other change in between. The bench's reference model advances a phase counter on the same edges, and all four outputs are compared against it at every falling edge. As a result, an update that lands a cycle early or late, or a value that moves outside its update edge, is caught at once. Inputs are scrambled on the cycle after each accepted tick to expose any use of live rather than captured values.

// File: rtl/cam_scroll_pkg.sv
package cam_scroll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FOLLOW,
        ST_CLAMP,
        ST_EMIT
    } cam_state_e;

    localparam int NUM_AXES   = 2;
    localparam int NUM_LAYERS = 2;

endpackage

// File: rtl/cam_seq_fsm.sv
module cam_seq_fsm
    import cam_scroll_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_tick,
    output cam_state_e state,
    output logic       lat_en,
    output logic       step_en,
    output logic       clamp_en,
    output logic       emit_en
);

    cam_state_e state_q;
    cam_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept, step, settle, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (frame_tick) state_d = ST_FOLLOW;
            ST_FOLLOW: state_d = ST_CLAMP;
            ST_CLAMP:  state_d = ST_EMIT;
            ST_EMIT:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // stage enables
    always_comb begin
        lat_en   = 1'b0;
        step_en  = 1'b0;
        clamp_en = 1'b0;
        emit_en  = 1'b0;
        unique case (state_q)
            ST_IDLE:   lat_en   = frame_tick;
            ST_FOLLOW: step_en  = 1'b1;
            ST_CLAMP:  clamp_en = 1'b1;
            ST_EMIT:   emit_en  = 1'b1;
            default:   ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/cam_axis.sv
module cam_axis #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lat_en,
    input  logic                step_en,
    input  logic                clamp_en,
    input  logic signed [W-1:0] tgt,
    input  logic signed [W-1:0] lo,
    input  logic signed [W-1:0] hi,
    output logic signed [W-1:0] pos,
    output logic signed [W-1:0] lo_cap,
    output logic signed [W-1:0] hi_cap
);

    localparam int EXT_W = W + 1;

    logic signed [W-1:0]     tgt_q, lo_q, hi_q;
    logic signed [W-1:0]     raw_q, pos_q;
    logic signed [EXT_W-1:0] tgt_ext, pos_ext, diff;
    logic signed [W-1:0]     raw_nx, lim_hi, lim_both;

    assign tgt_ext = {tgt_q[W-1], tgt_q};
    assign pos_ext = {pos_q[W-1], pos_q};
    assign diff    = tgt_ext - pos_ext;
    // halfway point lies between camera and target, so it fits in W bits
    assign raw_nx  = W'(pos_ext + (diff >>> 1));

    assign lim_hi   = (raw_q > hi_q) ? hi_q : raw_q;
    assign lim_both = (lim_hi < lo_q) ? lo_q : lim_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
            raw_q <= '0;
            pos_q <= '0;
        end else begin
            if (lat_en) begin
                tgt_q <= tgt;
                lo_q  <= lo;
                hi_q  <= hi;
            end
            if (step_en)  raw_q <= raw_nx;
            if (clamp_en) pos_q <= lim_both;
        end
    end

    assign pos    = pos_q;
    assign lo_cap = lo_q;
    assign hi_cap = hi_q;

endmodule

// File: rtl/scroll_map.sv
module scroll_map #(
    parameter int W     = 16,
    parameter int O     = 8,
    parameter int SHIFT = 0
) (
    input  logic signed [W-1:0] px,
    input  logic signed [W-1:0] py,
    input  logic        [O-1:0] corr,
    input  logic                inv,
    output logic      [2*O-1:0] word
);

    logic signed [W-1:0] sx, sy;
    logic [O-1:0] xb, yb, ylow;

    assign sx   = px >>> SHIFT;
    assign sy   = py >>> SHIFT;
    assign xb   = O'(sx);
    assign ylow = O'(sy);
    assign yb   = inv ? O'(corr - ylow) : ylow;
    assign word = {yb, xb};

endmodule

// File: rtl/cam_scroll_unit.sv
module cam_scroll_unit
    import cam_scroll_pkg::*;
#(
    parameter int POS_W = 16,
    parameter int OFS_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_tick,
    input  logic signed [POS_W-1:0] tgt_x,
    input  logic signed [POS_W-1:0] tgt_y,
    input  logic signed [POS_W-1:0] min_x,
    input  logic signed [POS_W-1:0] max_x,
    input  logic signed [POS_W-1:0] min_y,
    input  logic signed [POS_W-1:0] max_y,
    input  logic        [OFS_W-1:0] y_corr,
    input  logic                    y_invert,
    output logic signed [POS_W-1:0] cam_x,
    output logic signed [POS_W-1:0] cam_y,
    output logic      [2*OFS_W-1:0] scr_main,
    output logic      [2*OFS_W-1:0] scr_para
);

    localparam int WORD_W = 2 * OFS_W;

    cam_state_e state_q;
    logic lat_en, step_en, clamp_en, emit_en;

    cam_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .state      (state_q),
        .lat_en     (lat_en),
        .step_en    (step_en),
        .clamp_en   (clamp_en),
        .emit_en    (emit_en)
    );

    logic signed [POS_W-1:0] ax_tgt [NUM_AXES];
    logic signed [POS_W-1:0] ax_lo  [NUM_AXES];
    logic signed [POS_W-1:0] ax_hi  [NUM_AXES];
    logic signed [POS_W-1:0] ax_pos [NUM_AXES];
    logic signed [POS_W-1:0] ax_loq [NUM_AXES];
    logic signed [POS_W-1:0] ax_hiq [NUM_AXES];

    assign ax_tgt[0] = tgt_x;
    assign ax_tgt[1] = tgt_y;
    assign ax_lo[0]  = min_x;
    assign ax_lo[1]  = min_y;
    assign ax_hi[0]  = max_x;
    assign ax_hi[1]  = max_y;

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        cam_axis #(.W(POS_W)) u_axis (
            .clk      (clk),
            .rst_n    (rst_n),
            .lat_en   (lat_en),
            .step_en  (step_en),
            .clamp_en (clamp_en),
            .tgt      (ax_tgt[a]),
            .lo       (ax_lo[a]),
            .hi       (ax_hi[a]),
            .pos      (ax_pos[a]),
            .lo_cap   (ax_loq[a]),
            .hi_cap   (ax_hiq[a])
        );
    end

    logic [OFS_W-1:0] corr_q;
    logic             inv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_q <= '0;
            inv_q  <= 1'b0;
        end else if (lat_en) begin
            corr_q <= y_corr;
            inv_q  <= y_invert;
        end
    end

    // layer 0 at full rate, layer 1 at half rate
    logic [WORD_W-1:0] lay_word [NUM_LAYERS];

    for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
        scroll_map #(.W(POS_W), .O(OFS_W), .SHIFT(l)) u_map (
            .px   (ax_pos[0]),
            .py   (ax_pos[1]),
            .corr (corr_q),
            .inv  (inv_q),
            .word (lay_word[l])
        );
    end

    logic [WORD_W-1:0] main_q, para_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q <= '0;
            para_q <= '0;
        end else if (emit_en) begin
            main_q <= lay_word[0];
            para_q <= lay_word[1];
        end
    end

    assign cam_x    = ax_pos[0];
    assign cam_y    = ax_pos[1];
    assign scr_main = main_q;
    assign scr_para = para_q;

endmodule

// File: rtl/cam_scroll_chk.sv
module cam_scroll_chk
    import cam_scroll_pkg::*;
#(
    parameter int POS_W = 16,
    parameter int OFS_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    frame_tick,
    input cam_state_e              state,
    input logic signed [POS_W-1:0] cam_x,
    input logic signed [POS_W-1:0] cam_y,
    input logic signed [POS_W-1:0] lo_x,
    input logic signed [POS_W-1:0] hi_x,
    input logic signed [POS_W-1:0] lo_y,
    input logic signed [POS_W-1:0] hi_y,
    input logic      [2*OFS_W-1:0] scr_main,
    input logic      [2*OFS_W-1:0] scr_para
);

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && frame_tick) |=> (state == ST_FOLLOW));

    p_window_x_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT && lo_x <= hi_x) |-> (cam_x >= lo_x && cam_x <= hi_x));

    p_window_y_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT && lo_y <= hi_y) |-> (cam_y >= lo_y && cam_y <= hi_y));

    p_main_x_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT) |=> (scr_main[OFS_W-1:0] == $past(cam_x[OFS_W-1:0])));

    p_para_x_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT) |=> (scr_para[OFS_W-1:0] == $past(cam_x[OFS_W:1])));

    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT) |=> (state == ST_IDLE));

    p_cam_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CLAMP) |=> ($stable(cam_x) && $stable(cam_y)));

    p_scr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_EMIT) |=> ($stable(scr_main) && $stable(scr_para)));

endmodule

bind cam_scroll_unit cam_scroll_chk #(.POS_W(POS_W), .OFS_W(OFS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .state      (state_q),
    .cam_x      (cam_x),
    .cam_y      (cam_y),
    .lo_x       (ax_loq[0]),
    .hi_x       (ax_hiq[0]),
    .lo_y       (ax_loq[1]),
    .hi_y       (ax_hiq[1]),
    .scr_main   (scr_main),
    .scr_para   (scr_para)
);

// File: tb/sim_cam_scroll_unit.sv
`timescale 1ns/1ps
module sim_cam_scroll_unit;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_tick = 1'b0;
    logic signed [15:0] tgt_x = '0, tgt_y = '0;
    logic signed [15:0] min_x = '0, max_x = '0, min_y = '0, max_y = '0;
    logic [7:0] y_corr = '0;
    logic y_invert = 1'b0;
    logic signed [15:0] cam_x, cam_y;
    logic [15:0] scr_main, scr_para;

    always #2.5 clk = ~clk;

    cam_scroll_unit u0 (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .tgt_x(tgt_x), .tgt_y(tgt_y),
        .min_x(min_x), .max_x(max_x), .min_y(min_y), .max_y(max_y),
        .y_corr(y_corr), .y_invert(y_invert),
        .cam_x(cam_x), .cam_y(cam_y), .scr_main(scr_main), .scr_para(scr_para)
    );

    integer checks = 0;
    integer errors = 0;
    bit     comparing = 1'b0;

    // behavioural reference
    integer m_ph = 0;
    integer m_tx, m_ty, m_lx, m_hx, m_ly, m_hy, m_corr, m_inv;
    integer r_x, r_y;
    integer e_cx = 0, e_cy = 0, e_main = 0, e_para = 0;

    function automatic integer limit(input integer v, input integer lo, input integer hi);
        integer c;
        c = v;
        if (c > hi) c = hi;
        if (c < lo) c = lo;
        return c;
    endfunction

    function automatic integer word_of(input integer cx, input integer cy,
                                       input integer corr, input integer inv, input integer sh);
        integer xv, yv, yb;
        xv = cx >>> sh;
        yv = cy >>> sh;
        yb = inv ? ((corr - yv) & 255) : (yv & 255);
        return yb * 256 + (xv & 255);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; e_cx = 0; e_cy = 0; e_main = 0; e_para = 0;
            r_x = 0; r_y = 0;
        end else begin
            case (m_ph)
                0: if (frame_tick) begin
                    m_tx = tgt_x; m_ty = tgt_y;
                    m_lx = min_x; m_hx = max_x; m_ly = min_y; m_hy = max_y;
                    m_corr = y_corr; m_inv = y_invert;
                    m_ph = 1;
                end
                1: begin
                    r_x = e_cx + ((m_tx - e_cx) >>> 1);
                    r_y = e_cy + ((m_ty - e_cy) >>> 1);
                    m_ph = 2;
                end
                2: begin
                    e_cx = limit(r_x, m_lx, m_hx);
                    e_cy = limit(r_y, m_ly, m_hy);
                    m_ph = 3;
                end
                default: begin
                    e_main = word_of(e_cx, e_cy, m_corr, m_inv, 0);
                    e_para = word_of(e_cx, e_cy, m_corr, m_inv, 1);
                    m_ph = 0;
                end
            endcase
        end
    end

    task automatic check(input bit ok, input string req, input integer act, input integer exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (comparing) begin
            check(cam_x == 16'(e_cx), "R1 R2 R3 R7 R8 cam_x", cam_x, e_cx);
            check(cam_y == 16'(e_cy), "R1 R2 R3 R7 R8 cam_y", cam_y, e_cy);
            check(scr_main == 16'(e_main), "R4 R6 R8 scr_main", scr_main, e_main);
            check(scr_para == 16'(e_para), "R5 R6 R8 scr_para", scr_para, e_para);
        end
    end

    task automatic frame(input integer tx, input integer ty,
                         input integer lx, input integer hx, input integer ly, input integer hy,
                         input integer corr, input bit inv);
        @(negedge clk);
        tgt_x = 16'(tx); tgt_y = 16'(ty);
        min_x = 16'(lx); max_x = 16'(hx); min_y = 16'(ly); max_y = 16'(hy);
        y_corr = 8'(corr); y_invert = inv;
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
        // scramble inputs: captured values must be used (R1)
        tgt_x = 16'sh1234; tgt_y = -16'sd999; min_x = 16'sd5; max_x = 16'sd6;
        min_y = 16'sd7; max_y = 16'sd8; y_corr = 8'hA5; y_invert = ~inv;
        repeat (4) @(negedge clk);
    endtask

    localparam integer LO = -32768;
    localparam integer HI = 32767;

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(cam_x == 0 && cam_y == 0, "R9 camera reset", cam_x, 0);
        check(scr_main == 0 && scr_para == 0, "R9 scroll reset", scr_main, 0);
        rst_n = 1'b1;
        comparing = 1'b1;
        @(negedge clk);

        // convergence with inverted Y (R2, R6)
        for (int i = 0; i < 6; i++) frame(100, -40, LO, HI, LO, HI, 16, 1'b1);
        // negative odd distances, floor rounding (R2, R5)
        for (int i = 0; i < 3; i++) frame(-101, 77, LO, HI, LO, HI, 200, 1'b1);
        // direct Y mode (R6)
        frame(-3000, -515, LO, HI, LO, HI, 0, 1'b0);
        frame(-3000, -515, LO, HI, LO, HI, 0, 1'b0);
        // pin camera at the minimum, then span the full range (R2, R3)
        frame(0, 0, LO, LO, LO, LO, 0, 1'b1);
        frame(HI, HI, LO, HI, LO, HI, 0, 1'b1);
        check(cam_x == -16'sd1, "R2 wide difference", cam_x, -1);
        // window limits (R3)
        frame(1000, -1000, 0, 50, -20, 40, 3, 1'b1);
        check(cam_x == 16'sd50 && cam_y == -16'sd20, "R3 window", cam_x, 50);
        frame(-1000, 1000, 0, 50, -20, 40, 3, 1'b0);
        // minimum above maximum: minimum wins (R3)
        frame(500, 500, 20, 10, 30, -30, 9, 1'b1);
        check(cam_x == 16'sd20 && cam_y == 16'sd30, "R3 min wins", cam_x, 20);
        // correction wrap (R6)
        frame(300, 255, LO, HI, LO, HI, 255, 1'b1);

        // tick held high for many cycles: only every fourth edge accepts (R7)
        @(negedge clk);
        tgt_x = 16'sd800; tgt_y = -16'sd800;
        min_x = 16'(LO); max_x = 16'(HI); min_y = 16'(LO); max_y = 16'(HI);
        y_corr = 8'd40; y_invert = 1'b1;
        frame_tick = 1'b1;
        repeat (10) @(negedge clk);
        frame_tick = 1'b0;
        repeat (6) @(negedge clk);

        // idle stretch: nothing moves (R8)
        repeat (12) @(negedge clk);

        comparing = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule